// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the device side of a byte-wide parallel NOR flash bus. It samples every write cycle (a one-clock strobe with an address and a data byte) and works out which command the host is issuing. Commands are opened by a two-write unlock prefix on fixed low address values. After the prefix comes a command byte, and some commands then take further cycles: erase has a second unlock, secured-region exit has a trailing write, and write-buffer loading runs for a variable length.

Each recognised command is reported as a one-cycle event with a code, the address and data of the write that completed it, and a count field. Write-buffer loading is streamed as one event per loaded byte, carrying that byte's index, followed by a program event that carries the total byte count. The block keeps a mode register (read array, autoselect, CFI query, secured region, erase-suspend read) and a sticky abort flag for failed buffer writes.

The array itself, program and erase timing, and status bits are not modelled. A single input tells the decoder whether a sector erase is in progress.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read array), `cmd_valid` is 0 and `abort_flag` is 0.
- R2: Only the low 12 address bits are compared in unlock and command cycles. A write of AAh to low address AAAh, then 55h to 555h, then 90h to AAAh issues code 2 (autoselect) and sets `mode` to 1, whatever the upper address bits are. Every command event appears on the outputs one clock after the write that completes it.
- R3: A write that breaks a sequence (wrong data or wrong low address) discards that sequence, issues no event and leaves `mode` unchanged.
- R4: A single write of F0h to any address, outside data-carrying cycles, issues code 1 (reset). It sets `mode` to 4 (erase-suspend read) if an erase is suspended, and to 0 otherwise.
- R5: A single write of 98h to low address 0AAh issues code 3 and sets `mode` to 2 (CFI), but only from modes 0 or 1. From any other mode the write is ignored.
- R6: The unlock prefix followed by 88h at AAAh issues code 4 and sets `mode` to 3 (secured). While in mode 3, the unlock prefix, then 90h at AAAh, then 00h to any address issues code 5 and sets `mode` to 0.
- R7: The unlock prefix, then A0h at AAAh, then one write issues code 6 (program). The event carries that write's address and data.
- R8: The unlock prefix, 80h at AAAh, and the unlock prefix again, followed by 10h at AAAh, issues code 7 (chip erase). Followed instead by 30h at any address, it issues code 8 (sector erase) with that address. Erase is accepted only from mode 0.
- R9: Buffer write works as follows. After the unlock prefix, 25h is written to a sector address (sector = address bits 23:16), then N-1 to the same sector, then N writes, then 29h to the same sector. Each of the N writes issues code 9 with index 0..N-1 in `cmd_count`. The final write issues code 10 with `cmd_count` = N, for N from 1 to 32.
- R10: Any of the following sets `abort_flag` with no event: a count byte of 32 or more, a loaded address outside the 32-byte page of the first loaded address, or a confirm that is not 29h to the same sector. While the flag is set, every command other than the abort-reset is ignored, including a single F0h.
- R11: The unlock prefix followed by F0h at AAAh issues code 13 and clears `abort_flag`. The flag falls only together with this event.
- R12: A single B0h write issues code 11 (suspend) and sets `mode` to 4. This is accepted only while `erase_busy` is high and `mode` is 0. A single 30h write issues code 12 (resume) and sets `mode` to 0, but only from mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 24 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| erase_busy | input | 1 | High while a sector erase is running |
| cmd_valid | output | 1 | One-cycle command event |
| cmd_code | output | 4 | Command code (see requirements) |
| cmd_addr | output | 24 | Address of the completing write |
| cmd_data | output | 8 | Data of the completing write |
| cmd_count | output | 6 | Buffer byte index, or total count on buffer program |
| mode | output | 3 | Mode register |
| abort_flag | output | 1 | Sticky buffer-write abort |

## Verification
Every result (the command event, the new mode and the abort flag) is registered on the clock edge that samples the completing write, so each is due exactly one cycle after that write. The bench drives each write on a falling edge and holds it for one full cycle. It reads the outputs at the following falling edge, after the registering edge and before the next write, so a one-cycle event is always seen and an absent event is confirmed in the same slot. Buffer-length and overflow-count sweeps compute the expected index, count and abort outcome arithmetically.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_READ = 3'd0, M_AUTOSEL = 3'd1, M_CFI = 3'd2, M_SECURED = 3'd3, M_SUSP = 3'd4
  } mode_t;

  typedef enum logic [3:0] {
    C_NONE = 4'd0, C_RESET = 4'd1, C_AUTOSEL = 4'd2, C_CFI = 4'd3,
    C_SEC_ENTER = 4'd4, C_SEC_EXIT = 4'd5, C_PROGRAM = 4'd6, C_CHIP_ERASE = 4'd7,
    C_SECT_ERASE = 4'd8, C_BUF_LOAD = 4'd9, C_BUF_PROG = 4'd10, C_SUSPEND = 4'd11,
    C_RESUME = 4'd12, C_ABORT_RST = 4'd13
  } cmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_CMD, S_PROG, S_ER4, S_ER5, S_ER6, S_EXIT, S_BCNT, S_BLOAD, S_BCONF
  } seq_t;
endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
  parameter int ADDR_W   = 24,
  parameter int LOW_W    = 12,
  parameter int SECT_LSB = 16,
  parameter int PAGE_LSB = 5,
  localparam int SECT_W  = ADDR_W - SECT_LSB,
  localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              at_aaa,
  output logic              at_555,
  output logic              at_0aa,
  output logic [SECT_W-1:0] sector,
  output logic [PAGE_W-1:0] page
);
  logic [LOW_W-1:0] low;
  assign low    = addr[LOW_W-1:0];
  assign at_aaa = (low == LOW_W'('hAAA));
  assign at_555 = (low == LOW_W'('h555));
  assign at_0aa = (low == LOW_W'('h0AA));
  assign sector = addr[ADDR_W-1:SECT_LSB];
  assign page   = addr[ADDR_W-1:PAGE_LSB];
endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import fcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  cmd_t  code,
  output mode_t mode,
  output logic  susp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_READ;
      susp <= 1'b0;
    end else if (fire) begin
      case (code)
        C_RESET, C_ABORT_RST: mode <= susp ? M_SUSP : M_READ;
        C_AUTOSEL:   mode <= M_AUTOSEL;
        C_CFI:       mode <= M_CFI;
        C_SEC_ENTER: mode <= M_SECURED;
        C_SEC_EXIT:  mode <= M_READ;
        C_SUSPEND: begin mode <= M_SUSP; susp <= 1'b1; end
        C_RESUME:  begin mode <= M_READ; susp <= 1'b0; end
        default: ;
      endcase
    end
  end

  assert_resume_from_susp_R12: assert property (@(posedge clk) disable iff (rst)
    (fire && code == C_RESUME) |-> (mode == M_SUSP && susp));
  assert_cfi_entry_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && code == C_CFI) |-> (mode == M_READ || mode == M_AUTOSEL));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LOW_W    = 12,
  parameter int SECT_LSB = 16,
  parameter int PAGE_LSB = 5,
  parameter int MAX_BUF  = 32,
  localparam int SECT_W  = ADDR_W - SECT_LSB,
  localparam int PAGE_W  = ADDR_W - PAGE_LSB,
  localparam int CNT_W   = $clog2(MAX_BUF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              erase_busy,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [CNT_W-1:0]  cmd_count,
  output logic [2:0]        mode,
  output logic              abort_flag
);
  logic at_aaa, at_555, at_0aa;
  logic [SECT_W-1:0] sector, sect_q, n_sect;
  logic [PAGE_W-1:0] page, page_q, n_page;
  logic [CNT_W-1:0]  left_q, n_left, idx_q, n_idx, total_q, n_total;
  seq_t  state, n_state;
  cmd_t  n_code;
  mode_t mode_q;
  logic  susp_q, n_fire, n_abort, f0_reset, same_sect;

  fcd_addr_match #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .SECT_LSB(SECT_LSB), .PAGE_LSB(PAGE_LSB))
    i_match (.addr(wr_addr), .at_aaa(at_aaa), .at_555(at_555), .at_0aa(at_0aa),
             .sector(sector), .page(page));

  fcd_mode i_mode (.clk(clk), .rst(rst), .fire(n_fire), .code(n_code),
                   .mode(mode_q), .susp(susp_q));

  assign f0_reset  = (wr_data == 8'hF0) && !abort_flag;
  assign same_sect = (sector == sect_q);

  always_comb begin
    n_state = state;  n_fire = 1'b0;  n_code = C_NONE;  n_abort = abort_flag;
    n_sect = sect_q;  n_page = page_q;  n_left = left_q;  n_idx = idx_q;  n_total = total_q;
    if (wr_en) begin
      n_state = S_IDLE;
      case (state)
        S_IDLE: begin
          if (wr_data == 8'hAA && at_aaa) n_state = S_UL1;
          else if (f0_reset) begin n_fire = 1'b1; n_code = C_RESET; end
          else if (!abort_flag) begin
            if (wr_data == 8'h98 && at_0aa && (mode_q == M_READ || mode_q == M_AUTOSEL)) begin
              n_fire = 1'b1; n_code = C_CFI;
            end else if (wr_data == 8'hB0 && erase_busy && mode_q == M_READ && !susp_q) begin
              n_fire = 1'b1; n_code = C_SUSPEND;
            end else if (wr_data == 8'h30 && mode_q == M_SUSP) begin
              n_fire = 1'b1; n_code = C_RESUME;
            end
          end
        end
        S_UL1: begin
          if (wr_data == 8'h55 && at_555) n_state = S_CMD;
          else if (f0_reset) begin n_fire = 1'b1; n_code = C_RESET; end
        end
        S_CMD: begin
          if (wr_data == 8'hF0 && at_aaa) begin
            n_fire = 1'b1; n_code = C_ABORT_RST; n_abort = 1'b0;
          end else if (f0_reset) begin
            n_fire = 1'b1; n_code = C_RESET;
          end else if (!abort_flag) begin
            if (wr_data == 8'h25 && (mode_q == M_READ || mode_q == M_SECURED)) begin
              n_sect = sector; n_state = S_BCNT;
            end else if (at_aaa) begin
              case (wr_data)
                8'h90: if (mode_q == M_SECURED) n_state = S_EXIT;
                       else if (mode_q == M_READ || mode_q == M_SUSP) begin
                         n_fire = 1'b1; n_code = C_AUTOSEL;
                       end
                8'h88: if (mode_q == M_READ) begin n_fire = 1'b1; n_code = C_SEC_ENTER; end
                8'hA0: if (mode_q == M_READ || mode_q == M_SUSP || mode_q == M_SECURED)
                         n_state = S_PROG;
                8'h80: if (mode_q == M_READ) n_state = S_ER4;
                default: ;
              endcase
            end
          end
        end
        S_PROG: begin n_fire = 1'b1; n_code = C_PROGRAM; end
        S_ER4: begin
          if (wr_data == 8'hAA && at_aaa) n_state = S_ER5;
          else if (f0_reset) begin n_fire = 1'b1; n_code = C_RESET; end
        end
        S_ER5: begin
          if (wr_data == 8'h55 && at_555) n_state = S_ER6;
          else if (f0_reset) begin n_fire = 1'b1; n_code = C_RESET; end
        end
        S_ER6: begin
          if (wr_data == 8'h10 && at_aaa) begin n_fire = 1'b1; n_code = C_CHIP_ERASE; end
          else if (wr_data == 8'h30) begin n_fire = 1'b1; n_code = C_SECT_ERASE; end
          else if (f0_reset) begin n_fire = 1'b1; n_code = C_RESET; end
        end
        S_EXIT: begin
          if (wr_data == 8'h00) begin n_fire = 1'b1; n_code = C_SEC_EXIT; end
          else if (f0_reset) begin n_fire = 1'b1; n_code = C_RESET; end
        end
        S_BCNT: begin
          if (same_sect) begin
            if ({1'b0, wr_data} >= 9'(MAX_BUF)) n_abort = 1'b1;
            else begin
              n_left  = CNT_W'(wr_data) + CNT_W'(1);
              n_total = CNT_W'(wr_data) + CNT_W'(1);
              n_idx   = '0;
              n_state = S_BLOAD;
            end
          end
        end
        S_BLOAD: begin
          if (idx_q != '0 && page != page_q) n_abort = 1'b1;
          else begin
            if (idx_q == '0) n_page = page;
            n_fire  = 1'b1; n_code = C_BUF_LOAD;
            n_idx   = idx_q + CNT_W'(1);
            n_left  = left_q - CNT_W'(1);
            n_state = (left_q == CNT_W'(1)) ? S_BCONF : S_BLOAD;
          end
        end
        S_BCONF: begin
          if (wr_data == 8'h29 && same_sect) begin n_fire = 1'b1; n_code = C_BUF_PROG; end
          else n_abort = 1'b1;
        end
        default: n_state = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  abort_flag <= 1'b0;  cmd_valid <= 1'b0;
      cmd_code <= C_NONE;  cmd_addr <= '0;  cmd_data <= '0;  cmd_count <= '0;
      sect_q <= '0;  page_q <= '0;  left_q <= '0;  idx_q <= '0;  total_q <= '0;
    end else begin
      state <= n_state;  abort_flag <= n_abort;
      sect_q <= n_sect;  page_q <= n_page;  left_q <= n_left;  idx_q <= n_idx;  total_q <= n_total;
      cmd_valid <= n_fire;
      if (n_fire) begin
        cmd_code  <= n_code;
        cmd_addr  <= wr_addr;
        cmd_data  <= wr_data;
        cmd_count <= (n_code == C_BUF_LOAD) ? idx_q :
                     (n_code == C_BUF_PROG) ? total_q : '0;
      end
    end
  end

  assign mode = mode_q;

  assert_event_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_en));
  assert_abort_silent_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |-> !cmd_valid);
  assert_abort_clear_only_by_reset_seq_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(abort_flag) |-> (cmd_valid && cmd_code == C_ABORT_RST));
  assert_buf_count_range_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == C_BUF_PROG) |-> (cmd_count >= CNT_W'(1) && cmd_count <= CNT_W'(MAX_BUF)));
  assert_suspend_needs_erase_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == C_SUSPEND) |-> $past(erase_busy));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, erase_busy = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic cmd_valid, abort_flag;
  logic [3:0] cmd_code;
  logic [23:0] cmd_addr;
  logic [7:0] cmd_data;
  logic [5:0] cmd_count;
  logic [2:0] mode;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_busy(erase_busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_count(cmd_count),
    .mode(mode), .abort_flag(abort_flag));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ul(input logic [11:0] up);
    wr({up, 12'hAAA}, 8'hAA);
    wr({up, 12'h555}, 8'h55);
  endtask

  task automatic ev(input string req, input int code, input int md);
    chk(req, "cmd_valid", int'(cmd_valid), 1);
    chk(req, "cmd_code", int'(cmd_code), code);
    chk(req, "mode", int'(mode), md);
  endtask

  task automatic none(input string req, input int md);
    chk(req, "cmd_valid(none)", int'(cmd_valid), 0);
    chk(req, "mode", int'(mode), md);
  endtask

  task automatic abort_reset();
    ul(12'h000); wr(24'h000AAA, 8'hF0);
    ev("R11", 13, 0);
    chk("R11", "abort_flag", int'(abort_flag), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);
    chk("R1", "abort_flag", int'(abort_flag), 0);

    // R2 autoselect with upper address bits swept; R4 reset back to read
    for (int u = 0; u < 16; u++) begin
      logic [11:0] up;
      up = 12'(u * 273);
      ul(up); wr({up, 12'hAAA}, 8'h90);
      ev("R2", 2, 1);
      wr({up, 12'h3C1}, 8'hF0);
      ev("R4", 1, 0);
    end

    // R3 broken prefixes
    wr(24'h000AAA, 8'hAA); wr(24'h000554, 8'h55); wr(24'h000AAA, 8'h90);
    none("R3", 0);
    wr(24'h000AAB, 8'hAA); wr(24'h000555, 8'h55); wr(24'h000AAA, 8'h90);
    none("R3", 0);
    ul(12'h000); wr(24'h000AAA, 8'h91);
    none("R3", 0);

    // R5 CFI entry
    wr(24'h0000AB, 8'h98); none("R5", 0);
    wr(24'h7700AA, 8'h98); ev("R5", 3, 2);
    wr(24'h0000AA, 8'h98); none("R5", 2);
    wr(24'h000000, 8'hF0); ev("R4", 1, 0);
    ul(12'h000); wr(24'h000AAA, 8'h90); ev("R2", 2, 1);
    wr(24'h0000AA, 8'h98); ev("R5", 3, 2);
    wr(24'h000000, 8'hF0); ev("R4", 1, 0);

    // R6 secured region
    ul(12'h000); wr(24'h000AAA, 8'h88); ev("R6", 4, 3);
    wr(24'h0000AA, 8'h98); none("R5", 3);
    ul(12'h000); wr(24'h000AAA, 8'h90); none("R6", 3);
    wr(24'h123456, 8'h00); ev("R6", 5, 0);

    // R7 program
    ul(12'h000); wr(24'h000AAA, 8'hA0); none("R7", 0);
    wr(24'h123456, 8'h5A); ev("R7", 6, 0);
    chk("R7", "cmd_addr", int'(cmd_addr), 'h123456);
    chk("R7", "cmd_data", int'(cmd_data), 'h5A);

    // R8 erase
    ul(12'h000); wr(24'h000AAA, 8'h80); ul(12'h000); wr(24'h000AAA, 8'h10);
    ev("R8", 7, 0);
    ul(12'h000); wr(24'h000AAA, 8'h80); ul(12'h000); wr(24'h350000, 8'h30);
    ev("R8", 8, 0);
    chk("R8", "cmd_addr", int'(cmd_addr), 'h350000);
    ul(12'h000); wr(24'h000AAA, 8'h80); wr(24'h000AAA, 8'h10); none("R8", 0);

    // R9 buffer lengths 1..32
    for (int n = 1; n <= 32; n++) begin
      ul(12'h000); wr(24'h050000, 8'h25); wr(24'h050123, 8'(n - 1));
      none("R9", 0);
      for (int i = 0; i < n; i++) begin
        wr(24'h050040 + 24'(i), 8'(i) ^ 8'h3C);
        ev("R9", 9, 0);
        chk("R9", "load index", int'(cmd_count), i);
        chk("R9", "load data", int'(cmd_data), (i ^ 'h3C) & 'hFF);
      end
      wr(24'h050000, 8'h29);
      ev("R9", 10, 0);
      chk("R9", "byte count", int'(cmd_count), n);
      chk("R10", "abort_flag", int'(abort_flag), 0);
    end

    // R10 count overflow sweep, R11 abort reset
    for (int c = 32; c < 256; c++) begin
      ul(12'h000); wr(24'h050000, 8'h25); wr(24'h050000, 8'(c));
      none("R10", 0);
      chk("R10", "abort_flag", int'(abort_flag), 1);
      if (c == 32) begin
        ul(12'h000); wr(24'h000AAA, 8'h90); none("R10", 0);
        wr(24'h000000, 8'hF0); none("R10", 0);
        chk("R10", "abort_flag", int'(abort_flag), 1);
      end
      abort_reset();
    end
    // R10 page mismatch
    ul(12'h000); wr(24'h050000, 8'h25); wr(24'h050000, 8'h03);
    wr(24'h050040, 8'h11); ev("R9", 9, 0);
    wr(24'h050060, 8'h22); none("R10", 0);
    chk("R10", "abort_flag", int'(abort_flag), 1);
    abort_reset();
    // R10 confirm to wrong sector
    ul(12'h000); wr(24'h050000, 8'h25); wr(24'h050000, 8'h00);
    wr(24'h050040, 8'h11); ev("R9", 9, 0);
    wr(24'h060000, 8'h29); none("R10", 0);
    chk("R10", "abort_flag", int'(abort_flag), 1);
    abort_reset();

    // R12 suspend / resume
    wr(24'h000000, 8'hB0); none("R12", 0);
    wr(24'h000000, 8'h30); none("R12", 0);
    erase_busy = 1'b1;
    wr(24'h654321, 8'hB0); ev("R12", 11, 4);
    wr(24'h654321, 8'hB0); none("R12", 4);
    ul(12'h000); wr(24'h000AAA, 8'h90); ev("R2", 2, 1);
    wr(24'h000000, 8'hF0); ev("R4", 1, 4);
    wr(24'h111111, 8'h30); ev("R12", 12, 0);
    wr(24'h111111, 8'h30); none("R12", 0);
    erase_busy = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule